// File: doc/BRIEF.md
# Preset Block Error Down-Counter

This block keeps a running tally of transmission block errors by counting down from a programmable threshold. A superframe boundary strobe carries two active-low error flags: one for the near end and one for the far end. If either flag is low at a boundary, that superframe counts as one errored superframe. The count then drops by exactly one, however many flags are low.

When a counted error brings the count to zero, the block reloads the threshold. If the interrupt enable is set, it also raises a single-cycle interrupt request. The host can read the count at any time. The value returned is the threshold minus the errors seen since the last reload, and the read itself reloads the counter from the threshold.

The threshold sits in its own register. Writing that register never disturbs the running count, and a new threshold only takes effect at the next reload. Register address decoding belongs to the surrounding logic.

Top module: `block_error_countdown`

## Requirements
- R1: After reset, the count and the threshold both hold 0xFF, `irq_req` is 0 and `rd_data` is 0x00. The first read therefore returns 0xFF.
- R2: In a cycle with `sf_end` high and at least one of `far_ok`/`near_ok` low, the count drops by exactly one, even when both flags are low. With both flags high, the count does not change.
- R3: When `sf_end` is low, the levels of `far_ok` and `near_ok` have no effect on the count.
- R4: A counted error that finds the count at 0x01 or 0x00 does not decrement. Instead, the count is loaded with the threshold on that clock edge.
- R5: The edge that performs the R4 reload also sets `irq_req` for exactly one cycle, but only if `irq_en` is 1 in that cycle. In every other cycle, `irq_req` is 0.
- R6: A cycle with `rd_stb` high loads `rd_data` with the count as it stood before that edge and reloads the count from the threshold. `rd_data` holds its value until the next read.
- R7: When a read and a counted error fall in the same cycle, the read takes priority. `rd_data` receives the pre-error count, the error is discarded, and no interrupt is raised, even if the count was at 0x01.
- R8: A cycle with `thr_wr` high stores `thr_wdata` as the threshold without changing the count. A reload on that same edge still uses the previous threshold.
- R9: With a threshold of 0x00, every counted error reloads 0x00 and, with `irq_en` set, raises `irq_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thr_wr | input | 1 | Threshold register write strobe |
| thr_wdata | input | 8 | Threshold value to store |
| rd_stb | input | 1 | Host read strobe; reloads the count |
| rd_data | output | 8 | Count captured by the most recent read |
| sf_end | input | 1 | Superframe boundary strobe, one cycle |
| far_ok | input | 1 | Far-end block check result, 0 means errored |
| near_ok | input | 1 | Near-end block check result, 0 means errored |
| irq_en | input | 1 | Enable for the zero-reached interrupt |
| irq_req | output | 1 | One-cycle interrupt request |

## Verification
The assertions assume that `sf_end` and `rd_stb` are single-cycle strobes sampled synchronously. They also assume that `far_ok` and `near_ok` matter only in the strobe cycle, and that `thr_wdata` and `irq_en` are stable at the edge where they are used. The stimulus drives every input on the falling edge, and it never leaves a strobe high for longer than the cycle it stands for. The error flags are deliberately toggled outside strobe cycles, to show that they are ignored there.

// File: rtl/blkerr_pkg.sv
package blkerr_pkg;

  // A superframe counts as errored when the boundary strobe is present
  // and either active-low check flag reports a failure.
  function automatic logic is_errored(input logic boundary,
                                      input logic far_good,
                                      input logic near_good);
    return boundary && !(far_good && near_good);
  endfunction

  // A count of one or zero cannot take a further step: it reloads.
  function automatic logic at_floor(input int unsigned cnt);
    return cnt <= 1;
  endfunction

  function automatic int unsigned step_down(input int unsigned cnt);
    return cnt - 1;
  endfunction

endpackage

// File: rtl/blkerr_event.sv
module blkerr_event (
  input  logic sf_end,
  input  logic far_ok,
  input  logic near_ok,
  output logic err_evt
);
  import blkerr_pkg::*;

  always_comb err_evt = is_errored(sf_end, far_ok, near_ok);

endmodule

// File: rtl/blkerr_thresh.sv
module blkerr_thresh #(
  parameter int          W      = 8,
  parameter logic [W-1:0] PRESET = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         thr_wr,
  input  logic [W-1:0] thr_wdata,
  output logic [W-1:0] thr_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      thr_q <= PRESET;
    else if (thr_wr) thr_q <= thr_wdata;
  end

  p_thr_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr |=> thr_q == $past(thr_wdata));

  p_thr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !thr_wr |=> $stable(thr_q));

endmodule

// File: rtl/blkerr_count.sv
module blkerr_count #(
  parameter int           W      = 8,
  parameter logic [W-1:0] PRESET = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         err_evt,
  input  logic         rd_stb,
  input  logic         irq_en,
  input  logic [W-1:0] thr_q,
  output logic [W-1:0] rd_data,
  output logic         irq_req
);
  import blkerr_pkg::*;

  logic [W-1:0] cnt_q;
  logic         take_err;   // counted error not overridden by a read
  logic         hit_floor;  // counted error that reloads instead of stepping
  logic [W-1:0] cnt_d;

  always_comb begin
    take_err  = err_evt && !rd_stb;
    hit_floor = take_err && at_floor(32'(cnt_q));
    cnt_d     = cnt_q;
    if (rd_stb || hit_floor) cnt_d = thr_q;
    else if (take_err)       cnt_d = W'(step_down(32'(cnt_q)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= PRESET;
      rd_data <= '0;
      irq_req <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      irq_req <= hit_floor && irq_en;
      if (rd_stb) rd_data <= cnt_q;
    end
  end

  p_one_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (err_evt && !rd_stb && cnt_q > W'(1)) |=> cnt_q == $past(cnt_q) - W'(1));

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_evt && !rd_stb) |=> $stable(cnt_q));

  p_floor_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (err_evt && !rd_stb && cnt_q <= W'(1)) |=> cnt_q == $past(thr_q));

  p_irq_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> $past(err_evt && !rd_stb && irq_en && cnt_q <= W'(1)));

  p_irq_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |=> !irq_req || $past(err_evt && !rd_stb && irq_en));

  p_read_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> (rd_data == $past(cnt_q)) && (cnt_q == $past(thr_q)));

  p_read_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(rd_data));

  p_read_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && err_evt) |=> !irq_req);

endmodule

// File: rtl/block_error_countdown.sv
module block_error_countdown #(
  parameter int           W      = 8,
  parameter logic [W-1:0] PRESET = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         thr_wr,
  input  logic [W-1:0] thr_wdata,
  input  logic         rd_stb,
  output logic [W-1:0] rd_data,
  input  logic         sf_end,
  input  logic         far_ok,
  input  logic         near_ok,
  input  logic         irq_en,
  output logic         irq_req
);

  logic         err_evt;
  logic [W-1:0] thr_q;

  blkerr_event u_event (
    .sf_end  (sf_end),
    .far_ok  (far_ok),
    .near_ok (near_ok),
    .err_evt (err_evt)
  );

  blkerr_thresh #(.W(W), .PRESET(PRESET)) u_thresh (
    .clk       (clk),
    .rst_n     (rst_n),
    .thr_wr    (thr_wr),
    .thr_wdata (thr_wdata),
    .thr_q     (thr_q)
  );

  blkerr_count #(.W(W), .PRESET(PRESET)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .err_evt (err_evt),
    .rd_stb  (rd_stb),
    .irq_en  (irq_en),
    .thr_q   (thr_q),
    .rd_data (rd_data),
    .irq_req (irq_req)
  );

  p_quiet_when_disabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |=> !irq_req);

  p_floor_zero_thr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_q == '0 && !thr_wr && rd_stb) |=> rd_data == $past(u_count.cnt_q));

endmodule

// File: tb/block_error_countdown_bench.sv
module block_error_countdown_bench;

  typedef struct {
    logic [7:0] val;
    string      tag;
  } rd_item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       thr_wr = 1'b0;
  logic [7:0] thr_wdata = '0;
  logic       rd_stb = 1'b0;
  logic [7:0] rd_data;
  logic       sf_end = 1'b0;
  logic       far_ok = 1'b1;
  logic       near_ok = 1'b1;
  logic       irq_en = 1'b0;
  logic       irq_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  rd_item_t   exp_q[$];
  logic [7:0] m_cnt = 8'hFF;
  logic [7:0] m_thr = 8'hFF;

  always #5 clk = ~clk;

  block_error_countdown u_block_error_countdown (
    .clk(clk), .rst_n(rst_n), .thr_wr(thr_wr), .thr_wdata(thr_wdata),
    .rd_stb(rd_stb), .rd_data(rd_data), .sf_end(sf_end), .far_ok(far_ok),
    .near_ok(near_ok), .irq_en(irq_en), .irq_req(irq_req)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Monitor: pops the expected read result after every read edge.
  initial begin
    forever begin
      @(posedge clk);
      if (rd_stb) begin
        #1;
        if (exp_q.size() == 0) check("R6 unexpected read", rd_data, 8'hxx);
        else begin
          rd_item_t it;
          it = exp_q.pop_front();
          check(it.tag, rd_data, it.val);
        end
      end
    end
  end

  // Driver: one clock cycle of stimulus, model update, interrupt check.
  task automatic cyc(input logic sf, input logic far, input logic near,
                     input logic rd, input logic wr, input logic [7:0] wd,
                     input string tag);
    logic err;
    logic exp_irq;
    @(negedge clk);
    sf_end = sf; far_ok = far; near_ok = near; rd_stb = rd;
    thr_wr = wr; thr_wdata = wd;
    err = sf && !(far && near);
    exp_irq = 1'b0;
    if (rd) begin
      rd_item_t it;
      it.val = m_cnt; it.tag = tag;
      exp_q.push_back(it);
      m_cnt = m_thr;
    end else if (err) begin
      if (m_cnt == 8'h00 || m_cnt == 8'h01) begin
        m_cnt = m_thr;
        exp_irq = irq_en;
      end else m_cnt = m_cnt - 8'h01;
    end
    if (wr) m_thr = wd;
    @(posedge clk); #1;
    check({tag, " irq"}, {7'b0, irq_req}, {7'b0, exp_irq});
  endtask

  task automatic rd(input string tag);
    cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, tag);
  endtask

  task automatic err(input logic far, input logic near, input string tag);
    cyc(1'b1, far, near, 1'b0, 1'b0, 8'h00, tag);
  endtask

  task automatic wr(input logic [7:0] d, input string tag);
    cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, d, tag);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 irq at reset", {7'b0, irq_req}, 8'h00);
    check("R1 rd_data at reset", rd_data, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    rd("R1 first read");

    // R8: threshold write leaves the count alone
    wr(8'h05, "R8 write");
    err(1'b0, 1'b1, "R8 step");
    rd("R8 count kept");
    rd("R8 new threshold at reload");

    // R2: flag combinations
    err(1'b1, 1'b1, "R2 clean");
    err(1'b0, 1'b1, "R2 far");
    err(1'b1, 1'b0, "R2 near");
    err(1'b0, 1'b0, "R2 both single");
    rd("R2 result");

    // R3: flags without boundary strobe
    for (int i = 0; i < 4; i++) cyc(1'b0, 1'b0, i[0], 1'b0, 1'b0, 8'h00, "R3 no strobe");
    rd("R3 result");

    // R4/R5: reaching the floor with interrupt enabled
    irq_en = 1'b1;
    for (int i = 0; i < 5; i++) err(1'b0, 1'b0, "R5 floor");
    rd("R4 reloaded");
    // R5: disabled interrupt
    irq_en = 1'b0;
    for (int i = 0; i < 5; i++) err(1'b1, 1'b0, "R5 disabled");
    err(1'b0, 1'b1, "R5 step after reload");
    rd("R4 reload without irq");

    // R7: read collides with an error
    irq_en = 1'b1;
    err(1'b0, 1'b1, "R7 pre");
    err(1'b0, 1'b1, "R7 pre");
    cyc(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, "R7 collision");
    rd("R7 error dropped");
    for (int i = 0; i < 4; i++) err(1'b0, 1'b1, "R7 approach");
    cyc(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, "R7 collision at one");
    rd("R6 after collision");

    // R8: write on the same edge as a reload uses the old threshold
    wr(8'h02, "R8 write 2");
    rd("R8 drain");
    cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'h07, "R8 read with write");
    rd("R8 old threshold used");
    rd("R8 new threshold used");

    // R9: threshold zero
    wr(8'h00, "R9 write");
    rd("R9 load zero");
    err(1'b0, 1'b1, "R9 irq each");
    err(1'b1, 1'b0, "R9 irq each");
    err(1'b0, 1'b0, "R9 irq each");
    rd("R9 stays zero");

    @(negedge clk);
    rd_stb = 1'b0; sf_end = 1'b0; thr_wr = 1'b0;
    repeat (2) @(posedge clk);
    check("R6 queue drained", 8'(exp_q.size()), 8'h00);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule